// File: doc/BRIEF.md
# Serial-loaded five-bit bank controller

This block maps a CPU's program window and a picture unit's character window onto larger memories. It does this through four internal five-bit registers: a control word, two character bank selectors and one program bank selector. Software has no parallel path into these registers. Each CPU write in the upper half of the address space (address bit 15 set) carries one data bit. That bit is shifted into an accumulator, least significant bit first. The fifth such write moves the accumulated value into the register that the fifth write's address bits 14:13 select. A write whose data bit 7 is set aborts the sequence in progress and forces the control word into its default program layout. A separate external reset strobe returns the control and program registers to their defaults.

All outputs are decoded combinationally from the registers. The program side is given as four 8 KB slot bank numbers, and three layouts are available: one 32 KB window; a fixed first 16 KB with a switchable upper half; or a switchable lower half with a fixed last 16 KB. The character side is given as eight 1 KB slot bank numbers, built either from one 8 KB window or from two independent 4 KB halves. A two-bit field selects the nametable mirroring.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After rst_n is released, the control register holds 0x0C and the other three registers hold 0. The outputs are therefore: program slots 0,1,30,31; character slots 0..7; mirror_sel 0.
- R2: A write in the window whose data bit 7 is set empties the accumulator and its bit count, and ORs 0x0C into the control register. The other control bits are kept.
- R3: Each write in the window whose data bit 7 is clear stores data bit 0 at the next accumulator position, starting at bit 0. On the fifth such write, the five bits go to the register selected by that write's address bits 14:13 (00 control, 01 character 0, 10 character 1, 11 program), and the count restarts at zero.
- R4: Writes with address bit 15 clear change neither the accumulator count nor any register.
- R5: When control bit 3 is 0, program slots 0..3 are 2*B+0..3, where B is program register bits 3:0 with bit 0 forced to 0. Program register bit 4 is never used.
- R6: When control bits 3 and 2 are both 1, program slots 0,1 are 2*P and 2*P+1, where P is program register bits 3:0, and slots 2,3 are 30 and 31.
- R7: When control bit 3 is 1 and control bit 2 is 0, program slots 0,1 are 0 and 1, and slots 2,3 are 2*P and 2*P+1.
- R8: When control bit 4 is 0, character slots 0..7 are 4*C+0..7, where C is character register 0 with bit 0 cleared.
- R9: When control bit 4 is 1, character slots 0..3 are 4*C0+0..3 and slots 4..7 are 4*C1+0..3.
- R10: mirror_sel equals control bits 1:0, coded as 0 single-screen A, 1 single-screen B, 2 vertical, 3 horizontal.
- R11: ext_rst sets control to 0x0C, clears the program register, and empties the accumulator and count. The character registers keep their values. A window write in the same cycle is discarded.
- R12: Window writes on back-to-back clock cycles are each taken as a separate bit, with no filtering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one write per cycle when high |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ext_rst | input | 1 | External reset strobe for control, program register and accumulator |
| prg_bank | output | 20 | Four 5-bit 8 KB bank numbers, slot i at bits [5i+4:5i] |
| chr_bank | output | 56 | Eight 7-bit 1 KB bank numbers, slot i at bits [7i+6:7i] |
| mirror_sel | output | 2 | Mirroring select, coding as in R10 |

## Verification
Two events can coincide in one cycle: the external reset strobe and a CPU bit write into the window. The bench provokes this part-way through a load. It raises ext_rst in the same cycle as a write carrying a 1 bit, then loads a full five-bit control value. The result is correct only if the coincident write was dropped and the count restarted from zero; any stray bit would shift the committed value and show up in the program and character slot numbers. The bench also checks that a data-bit-7 write in the middle of a load preserves the low control bits, and that a commit follows the fifth write's address rather than the first's.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

  typedef enum logic [1:0] {
    MIR_ONE_A = 2'd0,
    MIR_ONE_B = 2'd1,
    MIR_VERT  = 2'd2,
    MIR_HORZ  = 2'd3
  } mirror_e;

  typedef enum logic [1:0] {
    PRG_WIDE32    = 2'd0,
    PRG_FIX_FIRST = 2'd1,
    PRG_FIX_LAST  = 2'd2
  } prg_layout_e;

  // Register indices carried by address bits 14:13
  localparam logic [1:0] IDX_CTRL = 2'd0;
  localparam logic [1:0] IDX_CHR0 = 2'd1;
  localparam logic [1:0] IDX_CHR1 = 2'd2;
  localparam logic [1:0] IDX_PRG  = 2'd3;

  // Control bits forced by the in-band reset and by the external strobe
  localparam logic [4:0] CTRL_DEFAULT = 5'h0C;

  function automatic prg_layout_e prg_layout(input logic ctl_b3, input logic ctl_b2);
    if (!ctl_b3)     return PRG_WIDE32;
    else if (ctl_b2) return PRG_FIX_LAST;
    else             return PRG_FIX_FIRST;
  endfunction

  function automatic mirror_e mirror_of(input logic [1:0] ctl_lo);
    return mirror_e'(ctl_lo);
  endfunction

endpackage

// File: rtl/sbc_shift_loader.sv
module sbc_shift_loader #(
  parameter int SHIFT_LEN = 5,
  localparam int CNT_W = $clog2(SHIFT_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_wr,
  input  logic                 bit_val,
  input  logic                 clear_req,
  output logic                 commit,
  output logic [SHIFT_LEN-1:0] commit_val,
  output logic [CNT_W-1:0]     cnt
);

  logic [SHIFT_LEN-1:0] acc_q;
  logic [SHIFT_LEN-1:0] bit_mask;
  logic                 last_bit;

  always_comb begin
    bit_mask = '0;
    for (int i = 0; i < SHIFT_LEN; i++) begin
      if (cnt == CNT_W'(i)) bit_mask[i] = 1'b1;
    end
  end

  assign last_bit   = (cnt == CNT_W'(SHIFT_LEN - 1));
  assign commit     = bit_wr && last_bit;
  assign commit_val = bit_val ? (acc_q | bit_mask) : acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt   <= '0;
    end else if (clear_req || commit) begin
      acc_q <= '0;
      cnt   <= '0;
    end else if (bit_wr) begin
      acc_q <= commit_val;
      cnt   <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/sbc_reg_bank.sv
module sbc_reg_bank
  import sbc_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [1:0]       commit_idx,
  input  logic [REG_W-1:0] commit_val,
  input  logic             reset_bit,
  input  logic             ext_rst,
  output logic [REG_W-1:0] ctrl,
  output logic [REG_W-1:0] chr0,
  output logic [REG_W-1:0] chr1,
  output logic [REG_W-1:0] prg
);

  localparam logic [REG_W-1:0] CTRL_RST = REG_W'(CTRL_DEFAULT);

  logic [REG_W-1:0] regs_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_reg
    localparam logic [REG_W-1:0] RST_VAL = (g == 0) ? CTRL_RST : '0;
    localparam bit               HARD    = (g == 0) || (g == 3);
    logic wr_hit;
    assign wr_hit = commit && (commit_idx == 2'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        regs_q[g] <= RST_VAL;
      end else if (HARD && ext_rst) begin
        regs_q[g] <= RST_VAL;
      end else if ((g == 0) && reset_bit) begin
        regs_q[g] <= regs_q[g] | CTRL_RST;
      end else if (wr_hit) begin
        regs_q[g] <= commit_val;
      end
    end
  end

  assign ctrl = regs_q[IDX_CTRL];
  assign chr0 = regs_q[IDX_CHR0];
  assign chr1 = regs_q[IDX_CHR1];
  assign prg  = regs_q[IDX_PRG];

endmodule

// File: rtl/sbc_prg_map.sv
module sbc_prg_map
  import sbc_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int PRG_SEL_W = 4,
  localparam int PRG_W    = PRG_SEL_W + 1
) (
  input  logic [REG_W-1:0]   ctrl,
  input  logic [REG_W-1:0]   prg_reg,
  output logic [4*PRG_W-1:0] prg_bank
);

  prg_layout_e          layout;
  logic [PRG_SEL_W-1:0] sel;
  logic [PRG_SEL_W-1:0] half [2];

  assign layout = prg_layout(ctrl[3], ctrl[2]);
  assign sel    = prg_reg[PRG_SEL_W-1:0];

  always_comb begin
    unique case (layout)
      PRG_FIX_LAST: begin
        half[0] = sel;
        half[1] = '1;
      end
      PRG_FIX_FIRST: begin
        half[0] = '0;
        half[1] = sel;
      end
      default: begin
        half[0] = {sel[PRG_SEL_W-1:1], 1'b0};
        half[1] = {sel[PRG_SEL_W-1:1], 1'b1};
      end
    endcase
  end

  for (genvar s = 0; s < 4; s++) begin : g_slot
    assign prg_bank[s*PRG_W +: PRG_W] = {half[s/2], 1'(s % 2)};
  end

endmodule

// File: rtl/sbc_chr_map.sv
module sbc_chr_map #(
  parameter int REG_W   = 5,
  localparam int CHR_W  = REG_W + 2
) (
  input  logic [REG_W-1:0]   ctrl,
  input  logic [REG_W-1:0]   chr0,
  input  logic [REG_W-1:0]   chr1,
  output logic [8*CHR_W-1:0] chr_bank
);

  logic             split4k;
  logic [REG_W-1:0] quad [2];

  assign split4k = ctrl[4];
  assign quad[0] = split4k ? chr0 : {chr0[REG_W-1:1], 1'b0};
  assign quad[1] = split4k ? chr1 : {chr0[REG_W-1:1], 1'b1};

  for (genvar s = 0; s < 8; s++) begin : g_slot
    assign chr_bank[s*CHR_W +: CHR_W] = {quad[s/4], 2'(s % 4)};
  end

endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int SHIFT_LEN = 5,
  parameter int PRG_SEL_W = 4,
  localparam int REG_W = SHIFT_LEN,
  localparam int PRG_W = PRG_SEL_W + 1,
  localparam int CHR_W = REG_W + 2,
  localparam int CNT_W = $clog2(SHIFT_LEN + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [15:0]        wr_addr,
  input  logic [7:0]         wr_data,
  input  logic               ext_rst,
  output logic [4*PRG_W-1:0] prg_bank,
  output logic [8*CHR_W-1:0] chr_bank,
  output logic [1:0]         mirror_sel
);

  // Named internal events, also observed by the checker
  logic             in_window;
  logic             accept_evt;
  logic             resetbit_evt;
  logic             bitwr_evt;
  logic             clear_evt;
  logic             commit_evt;
  logic [REG_W-1:0] commit_val;
  logic [CNT_W-1:0] shift_cnt;
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] chr0_q;
  logic [REG_W-1:0] chr1_q;
  logic [REG_W-1:0] prg_q;

  assign in_window    = wr_en && wr_addr[15];
  assign accept_evt   = in_window && !ext_rst;
  assign resetbit_evt = accept_evt && wr_data[7];
  assign bitwr_evt    = accept_evt && !wr_data[7];
  assign clear_evt    = resetbit_evt || ext_rst;

  sbc_shift_loader #(.SHIFT_LEN(SHIFT_LEN)) u_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_wr     (bitwr_evt),
    .bit_val    (wr_data[0]),
    .clear_req  (clear_evt),
    .commit     (commit_evt),
    .commit_val (commit_val),
    .cnt        (shift_cnt)
  );

  sbc_reg_bank #(.REG_W(REG_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (commit_evt),
    .commit_idx (wr_addr[14:13]),
    .commit_val (commit_val),
    .reset_bit  (resetbit_evt),
    .ext_rst    (ext_rst),
    .ctrl       (ctrl_q),
    .chr0       (chr0_q),
    .chr1       (chr1_q),
    .prg        (prg_q)
  );

  sbc_prg_map #(.REG_W(REG_W), .PRG_SEL_W(PRG_SEL_W)) u_prg (
    .ctrl     (ctrl_q),
    .prg_reg  (prg_q),
    .prg_bank (prg_bank)
  );

  sbc_chr_map #(.REG_W(REG_W)) u_chr (
    .ctrl     (ctrl_q),
    .chr0     (chr0_q),
    .chr1     (chr1_q),
    .chr_bank (chr_bank)
  );

  assign mirror_sel = mirror_of(ctrl_q[1:0]);

endmodule

// File: rtl/sbc_checker.sv
module sbc_checker #(
  parameter int REG_W = 5,
  parameter int PRG_W = 5,
  parameter int CNT_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [15:0]        wr_addr,
  input logic               ext_rst,
  input logic               bit_wr,
  input logic               commit,
  input logic               reset_bit,
  input logic [CNT_W-1:0]   shift_cnt,
  input logic [REG_W-1:0]   ctrl,
  input logic [REG_W-1:0]   prg_reg,
  input logic [4*PRG_W-1:0] prg_bank
);

  AST_COMMIT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (shift_cnt == '0)); // R3

  AST_RESET_BIT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_bit |=> (ctrl[3:2] == 2'b11) && (shift_cnt == '0)); // R2

  AST_OUTSIDE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr[15] && !ext_rst) |=> $stable(shift_cnt) && $stable(ctrl) && $stable(prg_reg)); // R4

  AST_EXT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst |=> (ctrl == REG_W'(5'h0C)) && (prg_reg == '0) && (shift_cnt == '0)); // R11

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr && !commit && !ext_rst) |=> (shift_cnt == $past(shift_cnt) + 1'b1)); // R12

  AST_FIXED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[3:2] == 2'b11) |-> (prg_bank[3*PRG_W +: PRG_W] == '1)); // R6

endmodule

bind serial_bank_ctrl sbc_checker #(.REG_W(REG_W), .PRG_W(PRG_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .ext_rst   (ext_rst),
  .bit_wr    (bitwr_evt),
  .commit    (commit_evt),
  .reset_bit (resetbit_evt),
  .shift_cnt (shift_cnt),
  .ctrl      (ctrl_q),
  .prg_reg   (prg_q),
  .prg_bank  (prg_bank)
);

// File: tb/serial_bank_ctrl_tb.sv
module serial_bank_ctrl_tb;

  localparam int PRG_W = 5;
  localparam int CHR_W = 7;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [15:0]        wr_addr = '0;
  logic [7:0]         wr_data = '0;
  logic               ext_rst = 1'b0;
  logic [4*PRG_W-1:0] prg_bank;
  logic [8*CHR_W-1:0] chr_bank;
  logic [1:0]         mirror_sel;

  int tests = 0;
  int fails = 0;
  int cyc   = 0;

  always #2.5 clk = ~clk;

  serial_bank_ctrl u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .ext_rst    (ext_rst),
    .prg_bank   (prg_bank),
    .chr_bank   (chr_bank),
    .mirror_sel (mirror_sel)
  );

  typedef struct packed {
    logic [4:0] ctrl, r1, r2, r3;
    logic [4:0] p0, p2;
    logic [6:0] c0, c4;
    logic [1:0] m;
  } vec_t;

  // ctrl, chr0, chr1, prg -> slot0, slot2, chr slot0, chr slot4, mirror
  localparam vec_t VEC [8] = '{
    '{5'h00, 5'd5,  5'd9,  5'd7,  5'd12, 5'd14, 7'd16,  7'd20,  2'd0},
    '{5'h0D, 5'd3,  5'd0,  5'd9,  5'd18, 5'd30, 7'd8,   7'd12,  2'd1},
    '{5'h0A, 5'd31, 5'd1,  5'd5,  5'd0,  5'd10, 7'd120, 7'd124, 2'd2},
    '{5'h1F, 5'd7,  5'h12, 5'd15, 5'd30, 5'd30, 7'd28,  7'd72,  2'd3},
    '{5'h13, 5'd0,  5'd31, 5'd15, 5'd28, 5'd30, 7'd0,   7'd124, 2'd3},
    '{5'h18, 5'd1,  5'd2,  5'd0,  5'd0,  5'd0,  7'd4,   7'd8,   2'd0},
    '{5'h04, 5'h10, 5'd3,  5'd3,  5'd4,  5'd6,  7'd64,  7'd68,  2'd0},
    '{5'h1C, 5'h1E, 5'h1F, 5'h10, 5'd0,  5'd30, 7'd120, 7'd124, 2'd0}
  };

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input int p0, input int p2,
                           input int c0, input int c4, input int m);
    for (int s = 0; s < 4; s++)
      chk(req, int'(prg_bank[s*PRG_W +: PRG_W]), (s < 2 ? p0 : p2) + (s % 2));
    for (int s = 0; s < 8; s++)
      chk(req, int'(chr_bank[s*CHR_W +: CHR_W]), (s < 4 ? c0 : c4) + (s % 4));
    chk(req, int'(mirror_sel), m);
  endtask

  task automatic put(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = a;
    wr_data = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0;
    ext_rst = 1'b0;
  endtask

  // Five back-to-back bit writes, LSB first, no idle in between
  task automatic load(input logic [15:0] a, input logic [4:0] v);
    for (int b = 0; b < 5; b++) put(a, {7'h00, v[b]});
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset state", 0, 30, 0, 4, 0);

    // Table walk: R3 address select, R5-R10 decode, R12 consecutive writes
    for (int i = 0; i < 8; i++) begin
      load(16'hA000 | 16'(i), VEC[i].r1);
      load(16'hDFFF, VEC[i].r2);
      load(16'hE123, VEC[i].r3);
      load(16'h9FFE, VEC[i].ctrl);
      check_all("R3 R5 R6 R7 R8 R9 R10 R12 table", VEC[i].p0, VEC[i].p2,
                VEC[i].c0, VEC[i].c4, VEC[i].m);
    end
    // state now: chr0=0x1E chr1=0x1F prg=0x10 ctrl=0x1C

    // R2: bit-7 write mid-load keeps low control bits and clears the count
    load(16'hE000, 5'd4);
    load(16'h8000, 5'h01);
    check_all("R2 setup", 8, 10, 120, 124, 1);
    put(16'h8000, 8'h01);
    put(16'h8000, 8'h01);
    put(16'hF000, 8'h80);
    idle();
    check_all("R2 in-band reset", 8, 30, 120, 124, 1);
    load(16'h8000, 5'h02);
    check_all("R2 count restart", 8, 10, 120, 124, 2);

    // R4: writes below 0x8000 interleaved in a load are not counted
    put(16'h8000, 8'h01);
    put(16'h8000, 8'h01);
    for (int k = 0; k < 5; k++) put(16'h7FFF, 8'h01);
    put(16'h8000, 8'h00);
    put(16'h8000, 8'h00);
    idle();
    check_all("R4 partial", 8, 10, 120, 124, 2);
    put(16'h8000, 8'h00);
    idle();
    check_all("R4 ignored writes", 8, 10, 120, 124, 3);

    // R11: external reset coincident with a window write
    load(16'hA000, 5'd6);
    put(16'h8000, 8'h01);
    put(16'h8000, 8'h01);
    put(16'h8000, 8'h01);
    @(negedge clk);
    ext_rst = 1'b1;
    wr_en   = 1'b1;
    wr_addr = 16'h8000;
    wr_data = 8'h01;
    idle();
    check_all("R11 ext reset", 0, 30, 24, 28, 0);
    load(16'h8000, 5'h10);
    check_all("R11 write dropped and count cleared", 0, 2, 24, 124, 0);

    // R3: commit target follows the fifth write's address
    put(16'h8000, 8'h01);
    put(16'h8000, 8'h00);
    put(16'h8000, 8'h01);
    put(16'h8000, 8'h00);
    put(16'hE000, 8'h00);
    idle();
    check_all("R3 fifth address wins", 8, 10, 24, 124, 0);

    // R12: a load straight after another, no idle cycle between
    for (int b = 0; b < 5; b++) put(16'hE000, {7'h00, b == 0 || b == 3});
    for (int b = 0; b < 5; b++) put(16'h8000, {7'h00, b == 2 || b == 3});
    idle();
    check_all("R12 back to back loads", 18, 30, 24, 28, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      tests++;
      fails++;
      $display("FAIL all: watchdog actual %0d cycles expected fewer", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule